// File: doc/BRIEF.md
# Shifted Second-Operand Unit

This block produces the second ALU operand of a 32-bit RISC datapath together with the shifter carry-out that flag logic may later consume. It is purely combinational. A two-bit source select chooses a plain 32-bit immediate, a register value shifted by a small immediate amount, or a register value shifted by an amount taken from the low byte of a second register. The register value is first adjusted when the register being read is the program counter. It then passes through a barrel shifter that supports logical left, logical right, arithmetic right, rotate right and a one-bit rotate through the carry flag.

The carry-out follows exact rules at the edges of the amount range. These edges are an amount of zero, an amount equal to the word width, and any larger amount. The downstream flag logic can therefore use the carry without any correction of its own. The ALU arithmetic, flag writeback and the register file sit outside this block. The caller supplies register values and the current carry flag, and it consumes the operand and the carry in the same cycle.

Top module: `shift_operand_unit`

## Requirements
- R1: Shift kind code 0 is logical left. For an amount n from 1 to 32, the result is the operand shifted left by n with zeros filled in, and the carry-out is operand bit 32−n.
- R2: Shift kind code 1 is logical right. For an amount n from 1 to 32, the result is the operand shifted right by n with zeros filled in, and the carry-out is operand bit n−1.
- R3: Shift kind code 2 is arithmetic right. For an amount n from 1 to 31, the vacated upper bits take the sign bit (bit 31) and the carry-out is operand bit n−1. For n of 32 or more, every result bit and the carry-out equal the sign bit.
- R4: For logical left or logical right with an amount above 32, the result is zero and the carry-out is 0.
- R5: Shift kind code 3 is rotate right. For a nonzero amount, the rotation is by the amount modulo 32, and the carry-out equals bit 31 of the rotated result.
- R6: Shift kind code 4 rotates right by one through the carry. The amount is ignored. Bit 31 of the result is the incoming carry, bits 30..0 are operand bits 31..1, and the carry-out is operand bit 0.
- R7: For shift kinds 0 to 3 with an amount of zero, the result is the operand unchanged and the carry-out equals the incoming carry.
- R8: Shift kind codes 5, 6 and 7 give a result of zero and pass the incoming carry through.
- R9: Source select 0 outputs the immediate unchanged and passes the incoming carry through. Select 1 shifts by the 5-bit immediate amount. Select 2 shifts by bits 7..0 of the amount register, and bits 31..8 of that register have no effect.
- R10: When a register source (select 1 or 2) reads register index 15, the value shifted is the register value plus 8 in 32-bit instruction state (state input 0) or plus 4 in 16-bit instruction state (state input 1). No other index is adjusted.
- R11: Source select 3 is unused. It outputs all ones and passes the incoming carry through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel | input | 2 | Operand source: 0 immediate, 1 register by immediate amount, 2 register by register amount, 3 unused |
| imm_word | input | 32 | Plain immediate operand |
| shift_kind | input | 3 | Shift type code, 0 to 4 defined |
| imm_amount | input | 5 | Shift amount for source select 1 |
| reg_index | input | 4 | Index of the register whose value is on reg_value |
| reg_value | input | 32 | Value of the register to be shifted |
| amt_reg_value | input | 32 | Value of the register holding the shift amount |
| narrow_state | input | 1 | 1 in 16-bit instruction state, 0 in 32-bit state |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Resulting second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Several checker properties use reg_value directly as the shifted operand. They therefore assume that the register index is not 15. For the same reason, the properties for the zero-amount and far-amount edges look only at the carry and at constant results, which do not depend on the program-counter adjustment. The sweeps keep the index at 3 and 7, apart from a dedicated group for the program-counter offset. That group uses a zero amount, so the expected value is the adjusted register value alone. All inputs are driven to defined values from the first clock, so the properties never see undefined data.

// File: rtl/shift_operand_pkg.sv
package shift_operand_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        SRC_IMM     = 2'd0,
        SRC_REG_IMM = 2'd1,
        SRC_REG_REG = 2'd2,
        SRC_UNUSED  = 2'd3
    } src_sel_e;

endpackage

// File: rtl/shift_rotator.sv
module shift_rotator #(
    parameter int DATA_W = 32,
    parameter int LOG_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [LOG_W-1:0]  rot_amt,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] stage [0:LOG_W];

    assign stage[0] = data_in;

    for (genvar s = 0; s < LOG_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = rot_amt[s]
            ? {stage[s][SH-1:0], stage[s][DATA_W-1:SH]}
            : stage[s];
    end

    assign data_out = stage[LOG_W];
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_operand_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [2:0]        kind,
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amount,
    input  logic              cin,
    output logic [DATA_W-1:0] result,
    output logic              cout
);
    localparam int LOG_W = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic [DATA_W:0]         lsl_ext;
    logic [DATA_W:0]         lsr_ext;
    logic signed [DATA_W:0]  asr_ext;
    logic [AMT_W-1:0]        asr_amt;
    logic [DATA_W-1:0]       ror_val;
    logic                    amt_zero;
    logic                    amt_far;

    assign amt_zero = (amount == '0);
    assign amt_far  = (amount > FULL_AMT);
    assign asr_amt  = amt_far ? FULL_AMT : amount;

    assign lsl_ext = {1'b0, src} << amount;
    assign lsr_ext = {src, 1'b0} >> amount;
    assign asr_ext = $signed({src, 1'b0}) >>> asr_amt;

    shift_rotator #(.DATA_W(DATA_W), .LOG_W(LOG_W)) u_rot (
        .data_in  (src),
        .rot_amt  (amount[LOG_W-1:0]),
        .data_out (ror_val)
    );

    always_comb begin
        result = '0;
        cout   = cin;
        unique case (kind)
            SK_LSL: begin
                if (amt_zero) begin
                    result = src;
                end else if (amt_far) begin
                    result = '0;
                    cout   = 1'b0;
                end else begin
                    result = lsl_ext[DATA_W-1:0];
                    cout   = lsl_ext[DATA_W];
                end
            end
            SK_LSR: begin
                if (amt_zero) begin
                    result = src;
                end else if (amt_far) begin
                    result = '0;
                    cout   = 1'b0;
                end else begin
                    result = lsr_ext[DATA_W:1];
                    cout   = lsr_ext[0];
                end
            end
            SK_ASR: begin
                if (amt_zero) begin
                    result = src;
                end else begin
                    result = asr_ext[DATA_W:1];
                    cout   = asr_ext[0];
                end
            end
            SK_ROR: begin
                if (amt_zero) begin
                    result = src;
                end else begin
                    result = ror_val;
                    cout   = ror_val[DATA_W-1];
                end
            end
            SK_RRX: begin
                result = {cin, src[DATA_W-1:1]};
                cout   = src[0];
            end
            default: begin
                result = '0;
                cout   = cin;
            end
        endcase
    end
endmodule

// File: rtl/operand_source.sv
module operand_source
    import shift_operand_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int AMT_W       = 8,
    parameter int IMM_AMT_W   = 5,
    parameter int IDX_W       = 4,
    parameter int PC_INDEX    = 15,
    parameter int WIDE_BYTES  = 4,
    parameter int NARROW_BYTES = 2
) (
    input  logic [1:0]        src_sel,
    input  logic [IMM_AMT_W-1:0] imm_amount,
    input  logic [IDX_W-1:0]  reg_index,
    input  logic [DATA_W-1:0] reg_value,
    input  logic [DATA_W-1:0] amt_reg_value,
    input  logic              narrow_state,
    output logic [DATA_W-1:0] shift_src,
    output logic [AMT_W-1:0]  shift_amt
);
    localparam logic [DATA_W-1:0] WIDE_OFS   = DATA_W'(2 * WIDE_BYTES);
    localparam logic [DATA_W-1:0] NARROW_OFS = DATA_W'(2 * NARROW_BYTES);
    localparam logic [IDX_W-1:0]  PC_IDX     = IDX_W'(PC_INDEX);

    logic amt_hi_unused;
    assign amt_hi_unused = ^amt_reg_value[DATA_W-1:AMT_W];

    always_comb begin
        if (reg_index == PC_IDX) begin
            shift_src = reg_value + (narrow_state ? NARROW_OFS : WIDE_OFS);
        end else begin
            shift_src = reg_value;
        end
    end

    always_comb begin
        if (src_sel == SRC_REG_IMM) begin
            shift_amt = AMT_W'(imm_amount);
        end else begin
            shift_amt = amt_reg_value[AMT_W-1:0];
        end
    end
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
    import shift_operand_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int AMT_W     = 8,
    parameter int IMM_AMT_W = 5,
    parameter int IDX_W     = 4
) (
    input  logic [1:0]           src_sel,
    input  logic [DATA_W-1:0]    imm_word,
    input  logic [2:0]           shift_kind,
    input  logic [IMM_AMT_W-1:0] imm_amount,
    input  logic [IDX_W-1:0]     reg_index,
    input  logic [DATA_W-1:0]    reg_value,
    input  logic [DATA_W-1:0]    amt_reg_value,
    input  logic                 narrow_state,
    input  logic                 carry_in,
    output logic [DATA_W-1:0]    operand_out,
    output logic                 carry_out
);
    logic [DATA_W-1:0] shift_src;
    logic [AMT_W-1:0]  shift_amt;
    logic [DATA_W-1:0] shift_res;
    logic              shift_cout;

    operand_source #(
        .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W), .IDX_W(IDX_W)
    ) u_src (
        .src_sel       (src_sel),
        .imm_amount    (imm_amount),
        .reg_index     (reg_index),
        .reg_value     (reg_value),
        .amt_reg_value (amt_reg_value),
        .narrow_state  (narrow_state),
        .shift_src     (shift_src),
        .shift_amt     (shift_amt)
    );

    shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .kind   (shift_kind),
        .src    (shift_src),
        .amount (shift_amt),
        .cin    (carry_in),
        .result (shift_res),
        .cout   (shift_cout)
    );

    always_comb begin
        unique case (src_sel)
            SRC_IMM: begin
                operand_out = imm_word;
                carry_out   = carry_in;
            end
            SRC_REG_IMM, SRC_REG_REG: begin
                operand_out = shift_res;
                carry_out   = shift_cout;
            end
            default: begin
                operand_out = '1;
                carry_out   = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/shift_operand_unit_chk.sv
module shift_operand_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int AMT_W     = 8,
    parameter int IMM_AMT_W = 5,
    parameter int IDX_W     = 4
) (
    input logic [1:0]           src_sel,
    input logic [DATA_W-1:0]    imm_word,
    input logic [2:0]           shift_kind,
    input logic [IMM_AMT_W-1:0] imm_amount,
    input logic [IDX_W-1:0]     reg_index,
    input logic [DATA_W-1:0]    reg_value,
    input logic [DATA_W-1:0]    amt_reg_value,
    input logic                 carry_in,
    input logic [DATA_W-1:0]    operand_out,
    input logic                 carry_out
);
    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic             from_reg;
    logic             reads_pc;
    logic [AMT_W-1:0] amt;

    assign from_reg = (src_sel == 2'd1) || (src_sel == 2'd2);
    assign reads_pc = (reg_index == IDX_W'(15));
    assign amt      = (src_sel == 2'd1) ? AMT_W'(imm_amount) : amt_reg_value[AMT_W-1:0];

    always_comb begin
        // R9: immediate source is untouched
        p_imm_pass_r9: assert (src_sel != 2'd0 ||
                               (operand_out == imm_word && carry_out == carry_in))
            else $error("p_imm_pass_r9");
        // R11: unused source gives all ones
        p_unused_fill_r11: assert (src_sel != 2'd3 ||
                                   (operand_out == '1 && carry_out == carry_in))
            else $error("p_unused_fill_r11");
        // R7: zero amount keeps the carry
        p_zero_amt_r7: assert (!(from_reg && amt == '0 && shift_kind < 3'd4) ||
                               carry_out == carry_in)
            else $error("p_zero_amt_r7");
        // R4: far logical shifts clear everything
        p_logic_far_r4: assert (!(from_reg && shift_kind < 3'd2 && amt > FULL_AMT) ||
                                (operand_out == '0 && carry_out == 1'b0))
            else $error("p_logic_far_r4");
        // R3: wide arithmetic shifts replicate the sign
        p_asr_fill_r3: assert (!(from_reg && !reads_pc && shift_kind == 3'd2 && amt >= FULL_AMT) ||
                               (operand_out == {DATA_W{reg_value[DATA_W-1]}} &&
                                carry_out == reg_value[DATA_W-1]))
            else $error("p_asr_fill_r3");
        // R5: rotate carry is the new top bit
        p_ror_carry_r5: assert (!(from_reg && shift_kind == 3'd3 && amt != '0) ||
                                carry_out == operand_out[DATA_W-1])
            else $error("p_ror_carry_r5");
        // R6: one-bit rotate through carry
        p_rrx_r6: assert (!(from_reg && !reads_pc && shift_kind == 3'd4) ||
                          (carry_out == reg_value[0] &&
                           operand_out == {carry_in, reg_value[DATA_W-1:1]}))
            else $error("p_rrx_r6");
    end
endmodule

bind shift_operand_unit shift_operand_unit_chk #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_AMT_W(IMM_AMT_W), .IDX_W(IDX_W)
) u_chk (
    .src_sel       (src_sel),
    .imm_word      (imm_word),
    .shift_kind    (shift_kind),
    .imm_amount    (imm_amount),
    .reg_index     (reg_index),
    .reg_value     (reg_value),
    .amt_reg_value (amt_reg_value),
    .carry_in      (carry_in),
    .operand_out   (operand_out),
    .carry_out     (carry_out)
);

// File: tb/shift_operand_unit_bench.sv
module shift_operand_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic [31:0] imm_word = '0;
    logic [2:0]  shift_kind = '0;
    logic [4:0]  imm_amount = '0;
    logic [3:0]  reg_index = 4'd3;
    logic [31:0] reg_value = '0;
    logic [31:0] amt_reg_value = '0;
    logic        narrow_state = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] operand_out;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    shift_operand_unit u_shift_operand_unit (
        .src_sel(src_sel), .imm_word(imm_word), .shift_kind(shift_kind),
        .imm_amount(imm_amount), .reg_index(reg_index), .reg_value(reg_value),
        .amt_reg_value(amt_reg_value), .narrow_state(narrow_state),
        .carry_in(carry_in), .operand_out(operand_out), .carry_out(carry_out)
    );

    // bitwise reference model built from the requirements
    function automatic logic [32:0] ref_shift(int kind, logic [31:0] op, int n, logic ci);
        logic [31:0] r = '0;
        logic c = ci;
        case (kind)
            0: if (n != 0) begin
                for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? op[i-n] : 1'b0;
                c = (n <= 32) ? op[32-n] : 1'b0;
            end else r = op;
            1: if (n != 0) begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? op[i+n] : 1'b0;
                c = (n <= 32) ? op[n-1] : 1'b0;
            end else r = op;
            2: if (n != 0) begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? op[i+n] : op[31];
                c = (n <= 32) ? op[n-1] : op[31];
            end else r = op;
            3: if (n != 0) begin
                for (int i = 0; i < 32; i++) r[i] = op[(i + n % 32) % 32];
                c = r[31];
            end else r = op;
            4: begin
                for (int i = 0; i < 31; i++) r[i] = op[i+1];
                r[31] = ci;
                c = op[0];
            end
            default: r = '0;
        endcase
        return {c, r};
    endfunction

    function automatic string tag_of(int kind, int n);
        if (kind > 4) return "R8";
        if (kind == 4) return "R6";
        if (n == 0) return "R7";
        if (kind < 2 && n > 32) return "R4";
        case (kind)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] exp_v, logic exp_c);
        checks++;
        if (operand_out !== exp_v || carry_out !== exp_c) begin
            failures++;
            $display("FAIL %s: got %08h/%0b expected %08h/%0b", tag,
                     operand_out, carry_out, exp_v, exp_c);
        end
    endtask

    task automatic apply_and_check(string tag, logic [31:0] exp_v, logic exp_c);
        @(negedge clk);
        check(tag, exp_v, exp_c);
        @(posedge clk);
    endtask

    initial begin
        logic [31:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'hFFFF_FFFF};
        logic [32:0] e;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // reset state: immediate source with zero inputs
        apply_and_check("R9 reset", 32'h0, 1'b0);

        // R9 immediate passes with carry
        for (int c = 0; c < 2; c++) begin
            src_sel = 2'd0; imm_word = 32'hDEAD_BEEF ^ c; carry_in = c[0];
            shift_kind = 3'd0; amt_reg_value = 32'h0000_0005;
            apply_and_check("R9 imm", 32'hDEAD_BEEF ^ c, c[0]);
        end
        // R11 unused select
        for (int c = 0; c < 2; c++) begin
            src_sel = 2'd3; carry_in = c[0];
            apply_and_check("R11", 32'hFFFF_FFFF, c[0]);
        end

        // register-amount sweep; upper amount bits noise (R9)
        src_sel = 2'd2; reg_index = 4'd3;
        for (int k = 0; k < 8; k++)
            for (int n = 0; n < 256; n++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 2; c++) begin
                        shift_kind = k[2:0]; reg_value = pats[p]; carry_in = c[0];
                        amt_reg_value = {24'h5A_3C_00 ^ {16'h0, n[7:0]}, n[7:0]};
                        e = ref_shift(k, pats[p], n, c[0]);
                        apply_and_check(tag_of(k, n), e[31:0], e[32]);
                    end

        // immediate-amount sweep, amount register must be ignored (R9)
        src_sel = 2'd1; reg_index = 4'd7; amt_reg_value = 32'hFFFF_FF21;
        for (int k = 0; k < 5; k++)
            for (int n = 0; n < 32; n++)
                for (int p = 0; p < 4; p++) begin
                    shift_kind = k[2:0]; imm_amount = n[4:0]; reg_value = pats[p]; carry_in = 1'b1;
                    e = ref_shift(k, pats[p], n, 1'b1);
                    apply_and_check("R9 imm-amount", e[31:0], e[32]);
                end

        // R10 program counter offset
        src_sel = 2'd2; shift_kind = 3'd0; amt_reg_value = '0; carry_in = 1'b0;
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++) begin
                narrow_state = s[0]; reg_index = 4'd15; reg_value = pats[p];
                apply_and_check("R10 pc", pats[p] + (s == 1 ? 32'd4 : 32'd8), 1'b0);
                reg_index = 4'd14;
                apply_and_check("R10 non-pc", pats[p], 1'b0);
            end
        // R10 with a shift applied after the offset
        reg_index = 4'd15; narrow_state = 1'b0; reg_value = 32'h0000_1000; amt_reg_value = 32'd4;
        apply_and_check("R10 pc shifted", 32'h0001_0080, 1'b0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule